// File: doc/BRIEF.md
# Serial Memory Slave with Pause and Status Lock

This block is the serial front end of a small byte-addressed memory. An external controller selects it with an active-low select, clocks bits in on a data input and reads bits back on a data output with an output enable. Every transfer starts with an opcode byte. The block can write and read the memory array, and it can read and write a status register. The array is a behavioural register file behind a byte-wide write port and read port. All pins are sampled by a fast system clock, so the serial clock acts as a data signal and is not used as a clock.

A pause input freezes a transfer in mid-byte and releases it later without losing the bit position. A lock bit in the status register works with an active-low protect pin to refuse status writes. After each accepted status write, a busy flag stays set for a fixed number of system cycles. The serial pins form the only data stream. The serial clock sets its pace, so the block applies no back-pressure and raises no ready. It must keep up with every serial clock edge. A serial half-period must therefore last at least three system cycles.

Top module: `spi_mem_slave`

## Requirements
- R1: Input bits are taken on each serial clock rise, most significant bit first, in 8-bit units. The first byte after select falls is the opcode: 0x01 writes status, 0x05 reads status, 0x02 writes memory, 0x03 reads memory. For the two memory opcodes, the second byte carries the start address in its low bits.
- R2: Output bits change only after a serial clock fall. The first read bit appears on the fall that follows the last rise of the preceding byte. A memory read returns consecutive addresses, and the address wraps from the top of the array back to 0. A memory write stores each complete data byte at consecutive addresses.
- R3: While select is high, the output enable is low.
- R4: After reset, nothing is decoded and the output enable stays low until select has gone from high to low.
- R5: The pause input enters and leaves the paused state only while the serial clock is low. While paused, the output enable is low and serial clock edges are ignored. On release the transfer resumes at the same bit.
- R6: The status byte is laid out as follows: bit 7 is the lock bit, bits 6 to 1 are free storage and bit 0 is a read-only busy flag. With lock at 1, a status write is refused if the protect pin is low when select rises. Memory writes and reads are unaffected by the protect pin.
- R7: With lock at 0, the protect pin has no effect on status writes.
- R8: With lock at 1, a fall of the protect pin at any time while select is low cancels the pending status write. A fall after the write has been accepted does not undo it.
- R9: A status write takes effect on the rise of select, and only if at least one data byte was received and no partial byte follows it.
- R10: After an accepted status write, busy reads 1 for BUSY_CYC system cycles. A status write or memory write whose opcode completes while busy is set is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock from the controller |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| wp_n | input | 1 | Active-low status write protect |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |

## Verification
A wrong bit counter or wrong phase shows up within one byte time. The bytes read back come out shifted or belong to the wrong address, and a write burst lands at displaced locations that the next read exposes. A bad pause state shows on the output enable while the pause is held, or as a one-bit slip in the byte after release. Mistakes in the protection or busy logic only appear on the next status read. The bench therefore reads the status right after each write attempt, to catch the busy bit, and again after the busy window has passed, to catch the stored value.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [7:0] OP_SR_WR  = 8'h01;
  localparam logic [7:0] OP_MEM_WR = 8'h02;
  localparam logic [7:0] OP_MEM_RD = 8'h03;
  localparam logic [7:0] OP_SR_RD  = 8'h05;

  typedef enum logic [1:0] {
    PH_OPC,
    PH_ADR,
    PH_DAT
  } phase_t;
endpackage

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int W = 8,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sck,
  input  logic         si,
  input  logic         hold_n,
  input  logic         tx_load,
  input  logic [W-1:0] tx_byte,
  output logic         rx_valid,
  output logic [W-1:0] rx_byte,
  output logic         frame_start,
  output logic         frame_end,
  output logic         bit_aligned,
  output logic         armed,
  output logic         held,
  output logic         so,
  output logic         so_oe
);
  logic          cs_q, sck_q;
  logic [CW-1:0] bit_cnt;
  logic [W-1:0]  rx_sh, tx_sh;
  logic          active, sck_rise, sck_fall;

  // cs_q resets low so that a select held low from reset is not a fall
  assign frame_start = cs_q && !cs_n;
  assign frame_end   = !cs_q && cs_n && armed;
  assign active      = armed && !cs_n;
  assign sck_rise    = sck && !sck_q;
  assign sck_fall    = !sck && sck_q;
  assign bit_aligned = (bit_cnt == '0);
  assign rx_byte     = rx_sh;
  assign so_oe       = active && !held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b0;
      sck_q    <= 1'b0;
      armed    <= 1'b0;
      held     <= 1'b0;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      so       <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      cs_q     <= cs_n;
      sck_q    <= sck;
      rx_valid <= 1'b0;
      if (frame_start) armed <= 1'b1;
      if (cs_n) begin
        held    <= 1'b0;
        bit_cnt <= '0;
        tx_sh   <= '0;
        so      <= 1'b0;
      end else if (active) begin
        // pause state may only change while the serial clock is low
        if (!sck) held <= !hold_n;
        if (!held && sck_rise) begin
          rx_sh <= {rx_sh[W-2:0], si};
          if (bit_cnt == CW'(W-1)) begin
            bit_cnt  <= '0;
            rx_valid <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (!held && sck_fall) begin
          so    <= tx_sh[W-1];
          tx_sh <= {tx_sh[W-2:0], 1'b0};
        end
        if (tx_load) tx_sh <= tx_byte;
      end
    end
  end
endmodule

// File: rtl/spim_array.sv
module spim_array #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int W = 8,
  parameter int AW = 4,
  parameter int BUSY_CYC = 400,
  localparam int BCW = $clog2(BUSY_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [W-1:0]  rx_byte,
  input  logic          frame_start,
  input  logic          frame_end,
  input  logic          bit_aligned,
  input  logic          wp_n,
  input  logic [W-1:0]  mem_rdata,
  output logic          tx_load,
  output logic [W-1:0]  tx_byte,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [W-1:0]  mem_wdata,
  output logic [AW-1:0] mem_raddr,
  output logic          sr_commit,
  output logic          busy,
  output logic          lock
);
  phase_t        phase;
  logic [W-1:0]  opcode;
  logic [AW-1:0] addr;
  logic [W-1:1]  sr_bits, pend_val;
  logic          pend, op_ok, in_frame, wp_q, wp_fell;
  logic [BCW-1:0] busy_cnt;
  logic          sr_rd, mem_rd;
  logic [W-1:0]  status;

  assign busy   = (busy_cnt != '0);
  assign lock   = sr_bits[W-1];
  assign status = {sr_bits, busy};

  assign sr_rd  = (phase == PH_OPC) ? (rx_byte == OP_SR_RD) : (opcode == OP_SR_RD);
  assign mem_rd = (phase != PH_OPC) && (opcode == OP_MEM_RD);

  assign tx_load   = rx_valid && (sr_rd || mem_rd);
  assign tx_byte   = sr_rd ? status : mem_rdata;
  assign mem_raddr = (phase == PH_ADR) ? rx_byte[AW-1:0] : addr;

  assign mem_we    = rx_valid && (phase == PH_DAT) && (opcode == OP_MEM_WR) && op_ok;
  assign mem_waddr = addr;
  assign mem_wdata = rx_byte;

  assign sr_commit = frame_end && pend && bit_aligned &&
                     !(lock && (wp_fell || !wp_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OPC;
      opcode   <= '0;
      addr     <= '0;
      sr_bits  <= '0;
      pend_val <= '0;
      pend     <= 1'b0;
      op_ok    <= 1'b0;
      in_frame <= 1'b0;
      wp_q     <= 1'b1;
      wp_fell  <= 1'b0;
      busy_cnt <= '0;
    end else begin
      wp_q <= wp_n;
      if (frame_start) begin
        phase    <= PH_OPC;
        opcode   <= '0;
        pend     <= 1'b0;
        in_frame <= 1'b1;
        wp_fell  <= 1'b0;
      end else if (in_frame && wp_q && !wp_n) begin
        wp_fell <= 1'b1;
      end

      if (rx_valid) begin
        unique case (phase)
          PH_OPC: begin
            opcode <= rx_byte;
            op_ok  <= !busy;
            phase  <= PH_ADR;
          end
          PH_ADR: begin
            phase <= PH_DAT;
            if (opcode == OP_MEM_RD) addr <= rx_byte[AW-1:0] + 1'b1;
            if (opcode == OP_MEM_WR) addr <= rx_byte[AW-1:0];
            if (opcode == OP_SR_WR && op_ok) begin
              pend_val <= rx_byte[W-1:1];
              pend     <= 1'b1;
            end
          end
          default: begin
            if (opcode == OP_MEM_RD || opcode == OP_MEM_WR) addr <= addr + 1'b1;
          end
        endcase
      end

      if (frame_end) begin
        in_frame <= 1'b0;
        pend     <= 1'b0;
      end

      if (sr_commit) begin
        sr_bits  <= pend_val;
        busy_cnt <= BCW'(BUSY_CYC);
      end else if (busy) begin
        busy_cnt <= busy_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  parameter int BUSY_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int AW = $clog2(DEPTH);

  logic          rx_valid, frame_start, frame_end, bit_aligned, armed, held;
  logic [W-1:0]  rx_byte, tx_byte, mem_rdata, mem_wdata;
  logic          tx_load, mem_we, sr_commit, busy, lock;
  logic [AW-1:0] mem_waddr, mem_raddr;

  spim_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .tx_load(tx_load), .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .frame_start(frame_start), .frame_end(frame_end), .bit_aligned(bit_aligned),
    .armed(armed), .held(held), .so(so), .so_oe(so_oe)
  );

  spim_ctrl #(.W(W), .AW(AW), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .frame_start(frame_start), .frame_end(frame_end), .bit_aligned(bit_aligned),
    .wp_n(wp_n), .mem_rdata(mem_rdata), .tx_load(tx_load), .tx_byte(tx_byte),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .sr_commit(sr_commit), .busy(busy), .lock(lock)
  );

  spim_array #(.W(W), .DEPTH(DEPTH)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic wp_n,
  input logic so_oe,
  input logic armed,
  input logic held,
  input logic busy,
  input logic sr_commit,
  input logic lock
);
  a_r3_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !so_oe);

  a_r4_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !so_oe);

  a_r5_paused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !so_oe);

  a_r6_pin_blocks_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_commit && lock) |-> wp_n);

  a_r9_lock_moves_on_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_commit |=> $stable(lock));

  a_r10_no_commit_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sr_commit |-> !busy);

  a_r10_busy_follows_commit: assert property (@(posedge clk) disable iff (!rst_n)
    sr_commit |=> busy);
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .so_oe(so_oe),
  .armed(armed), .held(held), .busy(busy), .sr_commit(sr_commit), .lock(lock)
);

// File: tb/spi_mem_slave_test.sv
module spi_mem_slave_test;
  logic clk = 1'b0;
  logic rst_n, cs_n, sck, si, hold_n, wp_n;
  logic so, so_oe;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_mem_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 1'b1; tick(4); cs_n = 1'b0; tick(4);
  endtask

  task automatic desel();
    tick(4); cs_n = 1'b1; tick(4);
  endtask

  task automatic xbit(input logic b, output logic r);
    si = b; tick(4); r = so; sck = 1'b1; tick(4); sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      logic rb;
      xbit(t[i], rb);
      r[i] = rb;
    end
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, v); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h01, d); xfer(v, d); desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, v;
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0; hold_n = 1'b1; wp_n = 1'b1;
    tick(5);
    chk("R4 reset so_oe", so_oe, 0);
    rst_n = 1'b1; tick(2);

    // R4: select low since reset, no fall yet: a status write must be ignored
    xfer(8'h01, d); xfer(8'h7E, d);
    chk("R4 unarmed so_oe", so_oe, 0);
    cs_n = 1'b1; tick(600);
    chk("R3 deselected so_oe", so_oe, 0);
    rdsr(v);
    chk("R4 status untouched", v, 8'h00);

    // R3: enable on when selected
    sel();
    chk("R3 selected so_oe", so_oe, 1);
    desel();

    // R9 and R10: accepted write shows busy, second write rejected
    wrsr(8'h3C);
    rdsr(v);
    chk("R10 busy set after commit", v, 8'h3D);
    wrsr(8'h42);
    tick(600);
    rdsr(v);
    chk("R10 write while busy ignored", v, 8'h3C);

    // R9: trailing partial byte blocks the commit
    sel(); xfer(8'h01, d); xfer(8'h66, d);
    for (int i = 0; i < 3; i++) begin logic rb; xbit(1'b1, rb); end
    desel(); tick(600);
    rdsr(v);
    chk("R9 partial byte no commit", v, 8'h3C);

    // R7: lock clear, pin low has no effect
    wp_n = 1'b0;
    wrsr(8'h5A); tick(600);
    rdsr(v);
    chk("R7 pin ignored when unlocked", v, 8'h5A);
    wp_n = 1'b1;

    wrsr(8'h92); tick(600);
    rdsr(v);
    chk("R6 lock set", v, 8'h92);

    // R6: locked with pin low, status write refused, memory still works
    wp_n = 1'b0;
    wrsr(8'hA4); tick(600);
    rdsr(v);
    chk("R6 locked write refused", v, 8'h92);

    // R1 R2: write burst from 0, read burst from 5 with wrap
    sel(); xfer(8'h02, d); xfer(8'h00, d);
    for (int a = 0; a < 16; a++) xfer(pat(a), d);
    desel();
    wp_n = 1'b1;
    sel(); xfer(8'h03, d); xfer(8'h05, d);
    for (int k = 0; k < 16; k++) begin
      xfer(8'h00, v);
      chk($sformatf("R2 read wrap addr %0d", (5 + k) % 16), v, pat((5 + k) % 16));
    end
    desel();

    // R8: pin falls and recovers inside a locked write: cancelled
    sel(); xfer(8'h01, d);
    wp_n = 1'b0; tick(4); wp_n = 1'b1;
    xfer(8'hB6, d); desel(); tick(600);
    rdsr(v);
    chk("R8 pin fall cancels", v, 8'h92);

    // R8: pin fall after acceptance does not undo
    wrsr(8'hC8);
    wp_n = 1'b0;
    rdsr(v);
    chk("R8 accepted despite later fall", v, 8'hC9);
    tick(600);
    rdsr(v);
    chk("R8 value kept", v, 8'hC8);
    wp_n = 1'b1;

    // R10: memory write right after a commit is ignored
    wrsr(8'h00);
    sel(); xfer(8'h02, d); xfer(8'h03, d); xfer(8'hEE, d); desel();
    tick(600);
    sel(); xfer(8'h03, d); xfer(8'h03, d); xfer(8'h00, v); desel();
    chk("R10 memory write while busy ignored", v, pat(3));

    // R5: pause mid-byte, extra clock ignored, resume at same bit
    sel(); xfer(8'h03, d); xfer(8'h09, d);
    for (int i = 7; i >= 5; i--) begin logic rb; xbit(1'b0, rb); v[i] = rb; end
    hold_n = 1'b0; tick(4);
    chk("R5 paused so_oe", so_oe, 0);
    sck = 1'b1; tick(4); sck = 1'b0; tick(4);
    hold_n = 1'b1; tick(4);
    chk("R5 resumed so_oe", so_oe, 1);
    for (int i = 4; i >= 0; i--) begin logic rb; xbit(1'b0, rb); v[i] = rb; end
    chk("R5 byte across pause", v, pat(9));
    xfer(8'h00, v);
    chk("R5 next byte after pause", v, pat(10));
    desel();

    // R1: single read at top of array
    sel(); xfer(8'h03, d); xfer(8'h0F, d); xfer(8'h00, v); xfer(8'h00, d); desel();
    chk("R1 read addr 15", v, pat(15));
    chk("R2 wrap to addr 0", d, pat(0));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule